// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked system read and write bytes in an external 32K x 8 asynchronous static RAM. On the system side, a request carries a 15-bit address, a write flag and a write byte. A one-cycle completion pulse returns the read byte. On the memory side, the block drives the address, three active-low strobes (chip select, output drive and write) and a split tri-state data bus (outgoing byte, incoming byte, drive enable). Every strobe and bus control comes straight from a flop.

The widths of the read wait and the write pulse are set in nanoseconds and derived at elaboration from the clock period. A read holds chip select and output drive low for the whole wait, then samples the byte. A write surrounds the write-strobe pulse with one cycle of data drive before the pulse and one cycle after it. The byte is committed on the rising edge of the write strobe. Chip select is high whenever no access is under way, so the memory sits in standby between accesses.

The requester raises `req_valid` with stable fields. The block takes the request in any cycle in which it is idle, including the cycle in which `req_ready` pulses. In that completion cycle the requester either drops `req_valid` or presents the next request.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset and whenever no access is under way: `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0 and `req_ready` is 0.
- R2: A read (`req_write`=0) holds `mem_ce_n`=0 and `mem_oe_n`=0 for exactly RD_CYC consecutive cycles, with `mem_we_n`=1 throughout. The first of these cycles follows the accepting clock edge.
- R3: The byte present on `mem_dq_in` in the last read cycle appears on `rsp_rdata` in the completion cycle. `rsp_rdata` changes only in a cycle in which `req_ready` is 1.
- R4: A write (`req_write`=1) runs for exactly WR_CYC+2 cycles with `mem_ce_n`=0 and `mem_oe_n`=1. These cycles are: one cycle with `mem_dq_oe`=1 and `mem_we_n`=1, then WR_CYC cycles with `mem_we_n`=0, then one cycle with `mem_we_n`=1, `mem_dq_oe`=1 and `mem_ce_n`=0.
- R5: While `mem_ce_n` is 0, `mem_addr` equals the accepted address. While `mem_dq_oe` is 1, `mem_dq_out` equals the accepted write byte.
- R6: `mem_dq_oe` is never 1 while `mem_ce_n` is 1 or while `mem_oe_n` is 0.
- R7: `req_ready` is 1 for exactly one cycle per transaction, in a cycle with all three strobes at 1.
- R8: The request fields are captured on the accepting edge. Changes to `req_valid`, `req_write`, `req_addr` or `req_wdata` during an access have no effect on that access or on memory.
- R9: When the next request is presented in the completion cycle, exactly one cycle with `mem_ce_n`=1 separates the two accesses.
- R10: RD_CYC = ceil(RD_ACCESS_NS*1000/CLK_PERIOD_PS)+1 and WR_CYC = ceil(WR_PULSE_NS*1000/CLK_PERIOD_PS)+1. With the defaults (5000 ps, 70 ns, 55 ns) these give 15 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when the block is idle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte, valid while `req_ready` is 1 |
| mem_addr | output | 15 | Address to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output drive request, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_in | input | 8 | Byte read from the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable, active high |

## Verification
The assertions assume two things about the environment. First, reset is held for at least one clock before the first request. Second, the requester never relies on a request being taken while an access is running; a `req_valid` raised mid-access is expected to be dropped before the completion cycle. The stimulus keeps to this. Each random request is withdrawn one cycle after acceptance, and its fields are overwritten with noise. One directed case raises a conflicting write request in the middle of a read and drops it well before that read's wait ends. The memory model returns a garbage byte until the access time has passed, so any early sample shows up as a data mismatch.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD
  } seq_state_t;

  // Cycles needed to cover a delay in ns, plus one cycle of margin.
  function automatic int unsigned wait_cycles(input int unsigned ns, input int unsigned clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps + 1;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
`timescale 1ns/1ps
module sram_ctrl_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/1ps
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC = 15,
  parameter int unsigned WR_CYC = 12,
  parameter int unsigned CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe,
  output logic             ready
);

  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);

  seq_state_t state_q, state_nxt;

  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign capture = (state_q == ST_READ) && tmr_expired;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = RD_LOAD;
    if (accept && !req_write) begin
      tmr_load = 1'b1;
      tmr_val  = RD_LOAD;
    end else if (state_q == ST_WSETUP) begin
      tmr_load = 1'b1;
      tmr_val  = WR_LOAD;
    end
  end

  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_nxt = req_write ? ST_WSETUP : ST_READ;
      ST_READ:   if (tmr_expired) state_nxt = ST_IDLE;
      ST_WSETUP: state_nxt = ST_WPULSE;
      ST_WPULSE: if (tmr_expired) state_nxt = ST_WHOLD;
      ST_WHOLD:  state_nxt = ST_IDLE;
      default:   state_nxt = ST_IDLE;
    endcase
  end

  // Strobes are registered from the next state so they leave flops directly.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      dq_oe   <= 1'b0;
      ready   <= 1'b0;
    end else begin
      state_q <= state_nxt;
      ce_n    <= (state_nxt == ST_IDLE);
      oe_n    <= (state_nxt != ST_READ);
      we_n    <= (state_nxt != ST_WPULSE);
      dq_oe   <= (state_nxt == ST_WSETUP) || (state_nxt == ST_WPULSE) ||
                 (state_nxt == ST_WHOLD);
      ready   <= capture || (state_q == ST_WHOLD);
    end
  end

endmodule

// File: rtl/sram_ctrl_dpath.sv
`timescale 1ns/1ps
module sram_ctrl_dpath #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_rdata <= '0;
    end else if (capture) begin
      rsp_rdata <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_bus_ctrl.sv
`timescale 1ns/1ps
module sram_bus_ctrl #(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_PS = 5000,
  parameter int unsigned RD_ACCESS_NS  = 70,
  parameter int unsigned WR_PULSE_NS   = 55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int unsigned RD_CYC  = sram_ctrl_pkg::wait_cycles(RD_ACCESS_NS, CLK_PERIOD_PS);
  localparam int unsigned WR_CYC  = sram_ctrl_pkg::wait_cycles(WR_PULSE_NS, CLK_PERIOD_PS);
  localparam int unsigned MAX_CYC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             accept;
  logic             capture;

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_ctrl_seq #(
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .accept      (accept),
    .capture     (capture),
    .ce_n        (mem_ce_n),
    .oe_n        (mem_oe_n),
    .we_n        (mem_we_n),
    .dq_oe       (mem_dq_oe),
    .ready       (req_ready)
  );

  sram_ctrl_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .capture    (capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
`timescale 1ns/1ps
module sram_bus_ctrl_chk #(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_PS = 5000,
  parameter int unsigned RD_ACCESS_NS  = 70,
  parameter int unsigned WR_PULSE_NS   = 55
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  localparam int unsigned RD_CYC = sram_ctrl_pkg::wait_cycles(RD_ACCESS_NS, CLK_PERIOD_PS);
  localparam int unsigned WR_CYC = sram_ctrl_pkg::wait_cycles(WR_PULSE_NS, CLK_PERIOD_PS);

  logic [31:0] we_lo_cnt;
  logic [31:0] oe_lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_lo_cnt <= '0;
      oe_lo_cnt <= '0;
    end else begin
      we_lo_cnt <= mem_we_n ? 32'd0 : we_lo_cnt + 32'd1;
      oe_lo_cnt <= mem_oe_n ? 32'd0 : oe_lo_cnt + 32'd1;
    end
  end

  AST_STANDBY_BUS_FREE: assert property (@(posedge clk) disable iff (rst)
    mem_ce_n |-> !mem_dq_oe); // R6
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe); // R6
  AST_WE_FRAMED: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe)); // R4
  AST_WE_FALL_SETUP: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> $past(mem_dq_oe)); // R4
  AST_WE_RISE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n)); // R4
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr)); // R5
  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R5
  AST_RDATA_ONLY_ON_READY: assert property (@(posedge clk) disable iff (rst)
    !$stable(rsp_rdata) |-> req_ready); // R3
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready); // R7
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n)); // R7
  AST_RD_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (oe_lo_cnt == RD_CYC)); // R2
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_lo_cnt == WR_CYC)); // R10

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(
  .ADDR_W        (ADDR_W),
  .DATA_W        (DATA_W),
  .CLK_PERIOD_PS (CLK_PERIOD_PS),
  .RD_ACCESS_NS  (RD_ACCESS_NS),
  .WR_PULSE_NS   (WR_PULSE_NS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .rsp_rdata  (rsp_rdata),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/test_sram_bus_ctrl.sv
`timescale 1ns/1ps
module test_sram_bus_ctrl;

  localparam int CLK_PS = 5000;
  localparam int RD_NS  = 70;
  localparam int WR_NS  = 55;

  function automatic int need_cycles(input int ns);
    return (ns * 1000 + CLK_PS - 1) / CLK_PS + 1;
  endfunction

  localparam int EXP_RD  = need_cycles(RD_NS);
  localparam int EXP_WR  = need_cycles(WR_NS);
  localparam int ACC_CYC = (RD_NS * 1000 + CLK_PS - 1) / CLK_PS;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hEE;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sram_bus_ctrl #(
    .CLK_PERIOD_PS (CLK_PS),
    .RD_ACCESS_NS  (RD_NS),
    .WR_PULSE_NS   (WR_NS)
  ) i_sram_bus_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_ready  (req_ready),
    .rsp_rdata  (rsp_rdata),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_in  (mem_dq_in),
    .mem_dq_oe  (mem_dq_oe)
  );

  // ---------------- memory model ----------------
  logic [7:0] model_mem [int];
  logic [7:0] shadow [int];

  function automatic logic [7:0] power_up_byte(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
  endfunction

  function automatic logic [7:0] model_byte(input logic [14:0] a);
    if (model_mem.exists(int'(a))) return model_mem[int'(a)];
    return power_up_byte(a);
  endfunction

  function automatic logic [7:0] expect_byte(input logic [14:0] a);
    if (shadow.exists(int'(a))) return shadow[int'(a)];
    return power_up_byte(a);
  endfunction

  int acc_cnt = 0;
  always @(posedge clk) begin
    if (mem_ce_n === 1'b0 && mem_oe_n === 1'b0) acc_cnt <= acc_cnt + 1;
    else acc_cnt <= 0;
  end

  // Valid data only once the access time has elapsed; garbage before that.
  always @(negedge clk) begin
    if (mem_ce_n === 1'b0 && mem_oe_n === 1'b0 && acc_cnt >= ACC_CYC)
      mem_dq_in <= model_byte(mem_addr);
    else
      mem_dq_in <= 8'hEE;
  end

  always @(posedge mem_we_n) begin
    if (mem_ce_n === 1'b0 && mem_dq_oe === 1'b1) model_mem[int'(mem_addr)] = mem_dq_out;
  end

  always @(posedge mem_ce_n) begin
    if (mem_we_n === 1'b0 && mem_dq_oe === 1'b1) model_mem[int'(mem_addr)] = mem_dq_out;
  end

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ready, "R1",
            "idle strobes/ready", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 5'b11100);
    end
  endtask

  // Called at a negedge; returns at the negedge of the completion cycle.
  task automatic run_txn(input bit wr, input logic [14:0] a, input logic [7:0] d,
                         input bit poke, output int gap);
    int  cyc = 0, ce_lo = 0, oe_lo = 0, we_lo = 0;
    int  bad_fields = 0, contention = 0, seq_bad = 0;
    bit  seen_lo = 0, done = 0, prev_dq_oe = 0, prev_we_lo = 0;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    gap = mem_ce_n ? 1 : 0;
    while (!done && cyc < 200) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        if (poke) begin
          req_write = 1'b1;
          req_addr  = a ^ 15'd1;
          req_wdata = ~d;
        end else begin
          req_valid = 1'b0;
          req_write = ~wr;
          req_addr  = 15'($urandom);
          req_wdata = 8'($urandom);
        end
      end
      if (poke && cyc == 4) req_valid = 1'b0;
      if (!seen_lo) begin
        if (mem_ce_n) gap++;
        else seen_lo = 1;
      end
      if (!mem_ce_n) begin
        ce_lo++;
        if (mem_addr !== a) bad_fields++;
      end
      if (mem_dq_oe && mem_dq_out !== d) bad_fields++;
      if (!mem_oe_n) oe_lo++;
      if ((!mem_oe_n || mem_ce_n) && mem_dq_oe) contention++;
      if (!mem_we_n) begin
        we_lo++;
        if (!prev_dq_oe) seq_bad++;
      end
      if (prev_we_lo && mem_we_n && !(mem_dq_oe && !mem_ce_n)) seq_bad++;
      prev_dq_oe = mem_dq_oe;
      prev_we_lo = !mem_we_n;
      if (req_ready) done = 1;
    end
    check(done, "R7", "completion pulse seen", int'(done), 1);
    check(mem_ce_n && mem_oe_n && mem_we_n, "R7", "strobes high in ready cycle",
          {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    check(bad_fields == 0, "R5", "address/data held", bad_fields, 0);
    check(contention == 0, "R6", "bus drive while released", contention, 0);
    if (wr) begin
      check(we_lo == EXP_WR, "R10", "write pulse cycles", we_lo, EXP_WR);
      check(ce_lo == EXP_WR + 2, "R4", "write select cycles", ce_lo, EXP_WR + 2);
      check(oe_lo == 0 && seq_bad == 0, "R4", "write setup/hold/oe", oe_lo + seq_bad, 0);
      shadow[int'(a)] = d;
    end else begin
      check(oe_lo == EXP_RD, "R10", "read wait cycles", oe_lo, EXP_RD);
      check(ce_lo == EXP_RD && we_lo == 0, "R2", "read strobes", ce_lo * 100 + we_lo, EXP_RD * 100);
      check(rsp_rdata == expect_byte(a), "R3", "read byte", rsp_rdata, expect_byte(a));
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [14:0] pool [8];
    int g;
    void'($urandom(32'd20250611));
    for (int i = 0; i < 8; i++) pool[i] = 15'($urandom);
    pool[0] = 15'h0000;
    pool[1] = 15'h7FFF;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ready, "R1",
          "state during reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 5'b11100);
    rst = 1'b0;
    idle_cycles(2);

    // Directed corners: lowest and highest address, unwritten read.
    run_txn(1'b0, 15'h1234, 8'h00, 1'b0, g);
    idle_cycles(1);
    run_txn(1'b1, 15'h0000, 8'hA5, 1'b0, g);
    idle_cycles(1);
    run_txn(1'b1, 15'h7FFF, 8'h5A, 1'b0, g);
    run_txn(1'b0, 15'h0000, 8'h00, 1'b0, g);
    check(g == 1, "R9", "gap after back-to-back", g, 1);
    run_txn(1'b0, 15'h7FFF, 8'h00, 1'b0, g);
    check(g == 1, "R9", "gap read after read", g, 1);
    idle_cycles(1);

    // R8: conflicting request raised during a read must be ignored.
    run_txn(1'b1, 15'h0101, 8'hC3, 1'b0, g);
    idle_cycles(1);
    run_txn(1'b0, 15'h0100, 8'hC3, 1'b1, g);
    idle_cycles(2);
    run_txn(1'b0, 15'h0101, 8'h00, 1'b0, g);
    check(rsp_rdata == 8'hC3, "R8", "mid-access request ignored", rsp_rdata, 8'hC3);
    idle_cycles(1);

    // Constrained random mix.
    for (int t = 0; t < 150; t++) begin
      logic [14:0] a;
      bit wr, b2b;
      wr  = ($urandom % 2) == 1;
      a   = (($urandom % 4) != 0) ? pool[$urandom % 8] : 15'($urandom);
      b2b = ($urandom % 3) == 0;
      run_txn(wr, a, 8'($urandom), 1'b0, g);
      if (b2b) begin
        run_txn(($urandom % 2) == 1, pool[$urandom % 8], 8'($urandom), 1'b0, g);
        check(g == 1, "R9", "random back-to-back gap", g, 1);
      end
      idle_cycles(1 + ($urandom % 3));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #900000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule